// File: doc/BRIEF.md
# Dual-channel alternating PWM controller

This block is the digital timing and steering core of a two-output current-mode pulse width modulator. One counter-based oscillator produces a sawtooth that is split into a charge phase and a discharge phase. A toggle hands each oscillator period to channel 1 or channel 2 in turn. As a result, each gate output switches at half the oscillator rate, and its duty cycle stays below one half. The analog comparators, error amplifiers and drivers sit outside the block, and only their one-bit results enter it.

Each channel raises its gate at the start of its own charge phase. The gate ends at the first of these events: the sawtooth reaching the effective duty command, a current-sense trip after the leading-edge blanking window, or the end of charge. The effective command is the smaller of the per-channel duty input and a soft-start limit. That limit ramps up once per oscillator period after power-good and after every overcurrent restart. An overcurrent trip on either channel shuts both gates, waits one full oscillator period, and then restarts the oscillator, the toggle and the soft-start ramp from scratch. An external sync pulse, once it is wide enough, forces the oscillator into discharge. The sawtooth count is brought out for slope compensation.

Top module: `dual_pwm_ctrl`

## Requirements
- R1: After every start, oscillator periods alternate between channels, beginning with channel 1. A gate rises only when the sawtooth count is 0, and each gate's rise-to-rise interval in steady state is 2*(charge_len+discharge_len) clock cycles.
- R2: A gate stays high for min(duty, soft-start limit, charge_len) cycles. Both gates are low during discharge, a duty of 0 yields no pulse, and the two gates are never high together.
- R3: The soft-start limit is 0 while stopped. It equals SS_INC in the first period of a run and grows by SS_INC at each period end, saturating at all ones. With SS_INC=4 and duty 10, the first three pulses after a start are 4, 8 and 10 cycles wide.
- R4: For the first BLANK_CYC cycles of a pulse, the channel's cs_trip input has no effect on its gate.
- R5: A cs_trip that is high at a sampling edge after blanking drops that gate in the next cycle and keeps it low for the rest of the period. If cs_trip is held high, the pulse is BLANK_CYC+1 cycles wide. The other channel is unaffected.
- R6: While ch2_enable is low, gate2 is low. Channel 1 and the toggle sequence are unchanged, so the gate1 rise-to-rise interval stays 2*(charge_len+discharge_len).
- R7: sync_in must be high for SYNC_MIN consecutive sampling edges to count. The oscillator then enters discharge in the next cycle, which cuts the current pulse, and the next period goes to the other channel after discharge_len cycles. A shorter pulse has no effect, and a long pulse triggers only once.
- R8: An oc_trip on either channel drops both gates in the next cycle. The block then waits charge_len+discharge_len cycles, spends one preparation cycle, and restarts with channel 1 and a fresh soft-start ramp. A gate1 rise sampled together with the trip is followed by the next gate1 rise charge_len+discharge_len+2 cycles later.
- R9: During reset and while supply_ok is low, both gates and ramp are 0 and soft start stays at 0. A drop in supply_ok ends a pulse in the next cycle. After supply_ok returns, gate1 rises at the second clock edge.
- R10: ramp equals the charge-phase count: 0 in the cycle a gate rises, 1 in the next cycle, and 0 throughout discharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply good; low holds the block in lockout |
| sync_in | input | 1 | External oscillator sync pulse |
| ch2_enable | input | 1 | Channel 2 enable, active high |
| cs_trip1 | input | 1 | Channel 1 current-sense comparator result |
| cs_trip2 | input | 1 | Channel 2 current-sense comparator result |
| oc_trip1 | input | 1 | Channel 1 overcurrent comparator result |
| oc_trip2 | input | 1 | Channel 2 overcurrent comparator result |
| charge_len | input | CNT_W | Charge-phase length in cycles (0 acts as 1) |
| discharge_len | input | CNT_W | Discharge-phase length in cycles (0 acts as 1) |
| duty1 | input | CNT_W | Channel 1 duty command in cycles |
| duty2 | input | CNT_W | Channel 2 duty command in cycles |
| gate1 | output | 1 | Channel 1 gate-drive enable |
| gate2 | output | 1 | Channel 2 gate-drive enable |
| ramp | output | CNT_W | Sawtooth count for slope compensation |

## Verification
A wrong toggle state shows up within one oscillator period. Pulses then land on the wrong gate, or twice on one gate, and the scoreboard's ordered channel sequence breaks at the next falling edge. A soft-start or blanking counter that is off by one changes a pulse width, and a pulse width is compared the moment that pulse ends. A faulty restart or sync state machine shifts the next rising edge, so the bench times the interval from the triggering edge to that rise exactly.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic {
    PH_CHARGE = 1'b0,
    PH_DISCH  = 1'b1
  } osc_phase_t;

  typedef enum logic [1:0] {
    GD_HOLD  = 2'd0,
    GD_FAULT = 2'd1,
    GD_START = 2'd2,
    GD_RUN   = 2'd3
  } guard_state_t;
endpackage

// File: rtl/dpwm_osc.sv
module dpwm_osc
  import dpwm_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SYNC_MIN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_clr,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] chg_len,
  input  logic [CNT_W-1:0] dis_len,
  output osc_phase_t       phase,
  output logic [CNT_W-1:0] cnt,
  output logic             sel,
  output logic             cyc_end
);
  localparam int SW = $clog2(SYNC_MIN + 1);

  logic [SW-1:0]    sync_run;
  logic             sync_hit;
  logic [CNT_W-1:0] chg_last, dis_last;

  assign chg_last = (chg_len == '0) ? '0 : chg_len - CNT_W'(1);
  assign dis_last = (dis_len == '0) ? '0 : dis_len - CNT_W'(1);

  // width qualifier: counts consecutive high samples, fires once per pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sync_run <= '0;
    else if (!sync_in)                   sync_run <= '0;
    else if (sync_run != SW'(SYNC_MIN))  sync_run <= sync_run + SW'(1);
  end
  assign sync_hit = sync_in && (sync_run == SW'(SYNC_MIN - 1));

  assign cyc_end = !osc_clr && !sync_hit && (phase == PH_DISCH) && (cnt == dis_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CHARGE;
      cnt   <= '0;
      sel   <= 1'b0;
    end else if (osc_clr) begin
      phase <= PH_CHARGE;
      cnt   <= '0;
      sel   <= 1'b0;
    end else if (sync_hit) begin
      phase <= PH_DISCH;
      cnt   <= '0;
    end else if (phase == PH_CHARGE) begin
      if (cnt == chg_last) begin
        phase <= PH_DISCH;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      if (cnt == dis_last) begin
        phase <= PH_CHARGE;
        cnt   <= '0;
        sel   <= ~sel;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assert_sync_to_disch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && !osc_clr) |=> (phase == PH_DISCH && cnt == '0));

  assert_toggle_per_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (sel != $past(sel)));
endmodule

// File: rtl/dpwm_guard.sv
module dpwm_guard
  import dpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SS_INC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             ocp_any,
  input  logic [CNT_W-1:0] chg_len,
  input  logic [CNT_W-1:0] dis_len,
  input  logic             cyc_end,
  output logic             running,
  output logic [CNT_W-1:0] ss_lim
);
  localparam int PW = CNT_W + 1;

  guard_state_t     state;
  logic [PW-1:0]    ftimer, period_m1, ss_sum;
  logic [CNT_W-1:0] chg_eff, dis_eff, ss_step;

  assign chg_eff   = (chg_len == '0) ? CNT_W'(1) : chg_len;
  assign dis_eff   = (dis_len == '0) ? CNT_W'(1) : dis_len;
  assign period_m1 = {1'b0, chg_eff} + {1'b0, dis_eff} - PW'(1);
  assign ss_sum    = {1'b0, ss_lim} + PW'(SS_INC);
  assign ss_step   = ss_sum[CNT_W] ? '1 : ss_sum[CNT_W-1:0];
  assign running   = (state == GD_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= GD_HOLD;
      ftimer <= '0;
      ss_lim <= '0;
    end else if (!supply_ok) begin
      state  <= GD_HOLD;
      ftimer <= '0;
      ss_lim <= '0;
    end else begin
      unique case (state)
        GD_HOLD: begin
          state  <= GD_START;
          ss_lim <= '0;
        end
        GD_FAULT: begin
          ss_lim <= '0;
          if (ftimer == period_m1) begin
            state  <= GD_START;
            ftimer <= '0;
          end else begin
            ftimer <= ftimer + PW'(1);
          end
        end
        GD_START: begin
          state  <= ocp_any ? GD_FAULT : GD_RUN;
          ss_lim <= ocp_any ? '0 : CNT_W'(SS_INC);
        end
        GD_RUN: begin
          if (ocp_any) begin
            state  <= GD_FAULT;
            ftimer <= '0;
            ss_lim <= '0;
          end else if (cyc_end) begin
            ss_lim <= ss_step;
          end
        end
        default: state <= GD_HOLD;
      endcase
    end
  end

  assert_lockout_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (state == GD_HOLD && ss_lim == '0));

  assert_fault_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GD_RUN && supply_ok && ocp_any) |=> (state == GD_FAULT));

  assert_softstart_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GD_RUN && supply_ok && !ocp_any) |=> (ss_lim >= $past(ss_lim)));
endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan
  import dpwm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BLANK_CYC = 6,
  parameter int CH_ID     = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  osc_phase_t       phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             sel,
  input  logic             chan_en,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic [CNT_W-1:0] ss_lim,
  input  logic             trip,
  output logic             gate
);
  localparam int BW = $clog2(BLANK_CYC + 2);

  logic [CNT_W-1:0] eff;
  logic [BW-1:0]    blk;
  logic             blank_done, own, done;

  assign eff        = (duty_cmd < ss_lim) ? duty_cmd : ss_lim;
  assign own        = running && (phase == PH_CHARGE) && (sel == 1'(CH_ID));
  assign blank_done = (blk == BW'(BLANK_CYC));
  assign gate       = own && chan_en && !done && (cnt < eff);

  // blanking window measured from the gate's rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blk <= '0;
    else if (!gate)      blk <= '0;
    else if (!blank_done) blk <= blk + BW'(1);
  end

  // once the gate has dropped inside a charge phase it stays down until discharge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done <= 1'b0;
    else if (phase != PH_CHARGE || !running)
      done <= 1'b0;
    else if (!gate || (trip && blank_done))
      done <= 1'b1;
  end

  assert_trip_ends_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && trip && blank_done) |=> !gate);

  assert_rise_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> (cnt == '0));
endmodule

// File: rtl/dual_pwm_ctrl.sv
module dual_pwm_ctrl
  import dpwm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BLANK_CYC = 6,
  parameter int SYNC_MIN  = 1,
  parameter int SS_INC    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             sync_in,
  input  logic             ch2_enable,
  input  logic             cs_trip1,
  input  logic             cs_trip2,
  input  logic             oc_trip1,
  input  logic             oc_trip2,
  input  logic [CNT_W-1:0] charge_len,
  input  logic [CNT_W-1:0] discharge_len,
  input  logic [CNT_W-1:0] duty1,
  input  logic [CNT_W-1:0] duty2,
  output logic             gate1,
  output logic             gate2,
  output logic [CNT_W-1:0] ramp
);
  localparam int NCH = 2;

  osc_phase_t       phase;
  logic [CNT_W-1:0] cnt, ss_lim;
  logic             sel, cyc_end, running;
  logic [NCH-1:0]   gate_v, trip_v, en_v;
  logic [CNT_W-1:0] duty_v [NCH];

  assign trip_v    = {cs_trip2, cs_trip1};
  assign en_v      = {ch2_enable, 1'b1};
  assign duty_v[0] = duty1;
  assign duty_v[1] = duty2;

  dpwm_guard #(.CNT_W(CNT_W), .SS_INC(SS_INC)) u_guard (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .ocp_any(oc_trip1 | oc_trip2),
    .chg_len(charge_len), .dis_len(discharge_len),
    .cyc_end(cyc_end), .running(running), .ss_lim(ss_lim)
  );

  dpwm_osc #(.CNT_W(CNT_W), .SYNC_MIN(SYNC_MIN)) u_osc (
    .clk(clk), .rst_n(rst_n), .osc_clr(!running), .sync_in(sync_in),
    .chg_len(charge_len), .dis_len(discharge_len),
    .phase(phase), .cnt(cnt), .sel(sel), .cyc_end(cyc_end)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dpwm_chan #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC), .CH_ID(i)) u_chan (
      .clk(clk), .rst_n(rst_n), .running(running),
      .phase(phase), .cnt(cnt), .sel(sel),
      .chan_en(en_v[i]), .duty_cmd(duty_v[i]), .ss_lim(ss_lim),
      .trip(trip_v[i]), .gate(gate_v[i])
    );
  end

  assign gate1 = gate_v[0];
  assign gate2 = gate_v[1];
  assign ramp  = (running && phase == PH_CHARGE) ? cnt : '0;

  assert_gates_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate1 && gate2));

  assert_ch2_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ch2_enable |-> !gate2);
endmodule

// File: tb/dual_pwm_ctrl_test.sv
module dual_pwm_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int CHG = 20;
  localparam int DIS = 4;
  localparam int BLK = 3;
  localparam int SYN = 3;
  localparam int SSI = 4;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 1'b0, sync_in = 1'b0, ch2_enable = 1'b1;
  logic cs_trip1 = 1'b0, cs_trip2 = 1'b0, oc_trip1 = 1'b0, oc_trip2 = 1'b0;
  logic [W-1:0] charge_len = W'(CHG), discharge_len = W'(DIS);
  logic [W-1:0] duty1 = W'(10), duty2 = W'(10);
  logic gate1, gate2;
  logic [W-1:0] ramp;

  dual_pwm_ctrl #(.CNT_W(W), .BLANK_CYC(BLK), .SYNC_MIN(SYN), .SS_INC(SSI)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sync_in(sync_in),
    .ch2_enable(ch2_enable), .cs_trip1(cs_trip1), .cs_trip2(cs_trip2),
    .oc_trip1(oc_trip1), .oc_trip2(oc_trip2),
    .charge_len(charge_len), .discharge_len(discharge_len),
    .duty1(duty1), .duty2(duty2), .gate1(gate1), .gate2(gate2), .ramp(ramp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    ch;
    int    w;
    string tag;
  } pulse_t;

  pulse_t exp_q[$];
  int n_chk = 0, n_fail = 0, both_hi = 0, cyc = 0;
  int wid[2] = '{0, 0};
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_pulse(input int ch, input int w, input string tag);
    pulse_t p;
    p.ch = ch; p.w = w; p.tag = tag;
    exp_q.push_back(p);
  endtask

  // monitor: measure each pulse and compare against the scoreboard at its fall
  always @(negedge clk) begin
    if (rst_n) begin
      if (gate1 && gate2) both_hi++;
      for (int c = 0; c < 2; c++) begin
        logic g;
        g = (c == 0) ? gate1 : gate2;
        if (g) wid[c]++;
        else if (wid[c] > 0) begin
          if (exp_q.size() == 0) begin
            check(1'b0, $sformatf("R2 unexpected pulse on gate%0d width", c + 1), wid[c], 0);
          end else begin
            pulse_t e;
            e = exp_q.pop_front();
            check(e.ch == c + 1, {e.tag, " pulse channel"}, c + 1, e.ch);
            if (e.ch == c + 1) check(e.w == wid[c], {e.tag, " pulse width"}, wid[c], e.w);
          end
          wid[c] = 0;
        end
      end
    end
  end

  function automatic logic gsel(input int ch);
    return (ch == 1) ? gate1 : gate2;
  endfunction

  task automatic wait_rise(input int ch);
    logic p;
    int t;
    p = gsel(ch);
    t = 0;
    forever begin
      @(negedge clk);
      t++;
      if (gsel(ch) && !p) break;
      p = gsel(ch);
      if (t > 500) begin
        check(1'b0, "R1 timeout waiting for rise", t, 0);
        break;
      end
    end
  endtask

  task automatic wait_fall(input int ch);
    int t;
    t = 0;
    while (gsel(ch)) begin
      @(negedge clk);
      t++;
      if (t > 500) begin
        check(1'b0, "R2 timeout waiting for fall", t, 0);
        break;
      end
    end
  endtask

  task automatic wait_drain();
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual %0d cycles expected fewer", WATCHDOG);
    finish_run();
  end

  initial begin
    int t0;
    int hi;

    // reset and lockout (R9)
    repeat (3) @(negedge clk);
    check(!gate1 && !gate2, "R9 gates low in reset", gate1 + gate2, 0);
    check(ramp == 0, "R9 ramp zero in reset", ramp, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(!gate1 && !gate2, "R9 gates low in lockout", gate1 + gate2, 0);
    check(ramp == 0, "R9 ramp zero in lockout", ramp, 0);

    // start: soft start ramps 4, 8, then duty 10; ch1 first (R3, R1)
    expect_pulse(1, 4, "R3");
    expect_pulse(2, 8, "R3");
    expect_pulse(1, 10, "R2");
    expect_pulse(2, 10, "R2");
    expect_pulse(1, 10, "R1");
    expect_pulse(2, 10, "R1");
    supply_ok = 1'b1;
    wait_drain();

    // period and ramp (R1, R10)
    expect_pulse(1, 10, "R1");
    expect_pulse(2, 10, "R1");
    expect_pulse(1, 10, "R1");
    wait_rise(1);
    t0 = cyc;
    check(ramp == 0, "R10 ramp at rise", ramp, 0);
    @(negedge clk);
    check(ramp == 1, "R10 ramp one cycle after rise", ramp, 1);
    wait_rise(1);
    check(cyc - t0 == 2 * (CHG + DIS), "R1 gate1 rise-to-rise", cyc - t0, 2 * (CHG + DIS));
    wait_fall(1);
    @(negedge clk);

    // duty above charge length and zero duty (R2)
    duty1 = W'(30);
    duty2 = W'(0);
    expect_pulse(1, CHG, "R2 capped at charge");
    expect_pulse(1, CHG, "R2 capped at charge");
    wait_rise(1);
    wait_rise(1);
    wait_fall(1);
    @(negedge clk);
    duty1 = W'(10);
    duty2 = W'(10);

    // trip inside blanking ignored (R4)
    expect_pulse(2, 10, "R4");
    expect_pulse(1, 10, "R4");
    wait_rise(1);
    cs_trip1 = 1'b1;
    repeat (2) @(negedge clk);
    cs_trip1 = 1'b0;
    wait_fall(1);
    @(negedge clk);

    // held trip ends pulse after blanking; ch2 unaffected (R5)
    cs_trip1 = 1'b1;
    expect_pulse(2, 10, "R5 other channel");
    expect_pulse(1, BLK + 1, "R5");
    expect_pulse(2, 10, "R5 other channel");
    expect_pulse(1, BLK + 1, "R5");
    wait_rise(1);
    wait_rise(1);
    wait_fall(1);
    @(negedge clk);
    cs_trip1 = 1'b0;

    // channel 2 disabled (R6)
    ch2_enable = 1'b0;
    expect_pulse(1, 10, "R6");
    expect_pulse(1, 10, "R6");
    wait_rise(1);
    t0 = cyc;
    wait_rise(1);
    check(cyc - t0 == 2 * (CHG + DIS), "R6 gate1 period with ch2 off", cyc - t0, 2 * (CHG + DIS));
    wait_fall(1);
    @(negedge clk);
    ch2_enable = 1'b1;

    // short sync ignored (R7)
    expect_pulse(2, 10, "R7 short sync");
    expect_pulse(1, 10, "R7 short sync");
    wait_rise(1);
    sync_in = 1'b1;
    repeat (SYN - 1) @(negedge clk);
    sync_in = 1'b0;
    wait_fall(1);
    @(negedge clk);

    // qualified sync cuts pulse, next period to ch2 (R7)
    expect_pulse(2, 10, "R7");
    expect_pulse(1, SYN, "R7 sync cut");
    expect_pulse(2, 10, "R7");
    expect_pulse(1, 10, "R7");
    wait_rise(1);
    t0 = cyc;
    sync_in = 1'b1;
    repeat (SYN + 2) @(negedge clk);
    sync_in = 1'b0;
    wait_rise(2);
    check(cyc - t0 == SYN + DIS, "R7 ch2 rise after sync", cyc - t0, SYN + DIS);
    wait_rise(1);
    wait_fall(1);
    @(negedge clk);

    // overcurrent restart (R8)
    expect_pulse(2, 10, "R8");
    expect_pulse(1, 1, "R8 cut");
    expect_pulse(1, 4, "R8 restart");
    expect_pulse(2, 8, "R8 restart");
    expect_pulse(1, 10, "R8");
    expect_pulse(2, 10, "R8");
    wait_rise(1);
    t0 = cyc;
    oc_trip2 = 1'b1;
    @(negedge clk);
    oc_trip2 = 1'b0;
    wait_rise(1);
    check(cyc - t0 == CHG + DIS + 2, "R8 restart delay", cyc - t0, CHG + DIS + 2);
    wait_drain();

    // undervoltage lockout mid-pulse and recovery (R9)
    expect_pulse(1, 1, "R9 cut");
    wait_rise(1);
    supply_ok = 1'b0;
    hi = 0;
    repeat (30) begin
      @(negedge clk);
      if (gate1 || gate2 || ramp != 0) hi++;
    end
    check(hi == 0, "R9 outputs quiet in lockout", hi, 0);
    expect_pulse(1, 4, "R9 restart");
    expect_pulse(2, 8, "R9 restart");
    supply_ok = 1'b1;
    t0 = cyc;
    wait_rise(1);
    check(cyc - t0 == 2, "R9 restart latency", cyc - t0, 2);
    wait_drain();

    check(both_hi == 0, "R2 gates never overlap", both_hi, 0);
    finish_run();
  end
endmodule